// File: doc/BRIEF.md
# Super-Pixel Packet Frame Packer

The block gathers 30-bit super-pixel packets from a valid/ready stream and packs four of them into each 128-bit output frame. A frame opens with an 8-bit header: a fixed marker nibble followed by one even-parity bit per packet. The 120-bit payload behind it is whitened with an additive pseudo-random keystream, so that the line never sees long runs of identical bits.

The frame then leaves as a continuous byte stream, sixteen bytes per frame, with a flag on the first byte. That stream stands in for the input of a high-speed serializer. The output never pauses: whenever one frame finishes, the next is built from whatever packets have arrived. Empty slots are padded with an idle packet. A packet source that fills all four slots is held off until the waiting packets move into the output register.

Top module: `sp_frame_packer`

## Requirements
- R1: While `rst` is high, `out_valid` and `out_sof` are 0 and `in_ready` is 1. In the first cycle after `rst` falls, `out_valid` is still 0. From the next cycle on it is 1 and stays 1.
- R2: Each frame is 16 consecutive bytes. `out_sof` is 1 on the first byte of every frame and 0 on the other fifteen, so it repeats every 16 cycles.
- R3: The first byte of a frame is the header `{4'h5, p3, p2, p1, p0}`. Here pk is the XOR of all 30 bits of the unscrambled packet in slot k. The header is not scrambled.
- R4: Bytes 1 to 15 carry the 120-bit payload, most significant byte first. Slot 0 (the earliest packet accepted) sits in payload bits 119:90, slot 1 in 89:60, slot 2 in 59:30 and slot 3 in 29:0.
- R5: The payload is XORed with a keystream. Bit k of the keystream (k = 0 first) is applied to payload bit 119-k. A 7-bit state s is set to 7'h7F at every frame. Each keystream bit b equals s[6]^s[5], and then s becomes {s[5:0], b}.
- R6: Each slot that has no packet when a frame is loaded holds the idle packet 30'h0000_0000, whose parity bit is 0.
- R7: `in_ready` is 1 exactly while fewer than 4 packets wait for the next frame. Once it drops, it stays 0 until the cycle in which `out_sof` is 1.
- R8: Frames are loaded in the cycle before `out_sof` (and in the first cycle after reset). A packet accepted in that cycle goes to slot 0 of the following frame, not into the frame being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet offered |
| in_pkt | input | 30 | Super-pixel packet |
| in_ready | output | 1 | Packet accepted when high together with in_valid |
| out_valid | output | 1 | Byte stream running |
| out_sof | output | 1 | First (header) byte of a frame |
| out_byte | output | 8 | Frame byte, header first, then payload MSB first |

## Verification
The hardest boundary is a packet arriving in the last byte cycle of a frame. A design that slips it into the frame being loaded shows a shifted payload, and one that drops it loses a packet. Partial and fully idle frames are checked byte by byte: an implementation that leaves stale slot contents or seeds the keystream only once shows wrong payload or parity bits. Back-to-back bursts fill all four slots, so a ready signal that releases early or late causes lost or reordered packets. Patterns such as all-ones and alternating bits expose mistakes in the parity bits and in byte order.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int PKT_W    = 30;
    localparam int SLOTS    = 4;
    localparam int BYTE_W   = 8;
    localparam int PAY_W    = PKT_W * SLOTS;
    localparam int HDR_W    = 8;
    localparam int FRAME_W  = HDR_W + PAY_W;
    localparam int BYTES    = FRAME_W / BYTE_W;
    localparam int LFSR_W   = 7;

    localparam logic [3:0]        HDR_MARK  = 4'h5;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h7F;
    localparam logic [PKT_W-1:0]  IDLE_PKT  = '0;

    typedef logic [PKT_W-1:0] pkt_t;

    typedef struct packed {
        logic [3:0]       mark;
        logic [SLOTS-1:0] par;
    } hdr_t;

    typedef struct packed {
        hdr_t             hdr;
        logic [PAY_W-1:0] pay;
    } frame_t;

    typedef logic [BYTES-1:0][BYTE_W-1:0] frame_bytes_t;

    function automatic logic even_par(input pkt_t p);
        return ^p;
    endfunction

    // Fixed whitening mask: the generator restarts from the seed every frame.
    function automatic logic [PAY_W-1:0] keystream();
        logic [LFSR_W-1:0] s;
        logic [PAY_W-1:0]  ks;
        logic              b;
        s  = LFSR_SEED;
        ks = '0;
        for (int k = 0; k < PAY_W; k++) begin
            b             = s[6] ^ s[5];
            ks[PAY_W-1-k] = b;
            s             = {s[LFSR_W-2:0], b};
        end
        return ks;
    endfunction

endpackage

// File: rtl/spf_collector.sv
module spf_collector
    import spf_pkg::*;
#(
    parameter int N = SLOTS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  pkt_t               in_pkt,
    output logic               in_ready,
    input  logic               load,
    output pkt_t [N-1:0]       slots,
    output logic [N-1:0]       used
);
    localparam int CNT_W = $clog2(N + 1);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] wr_idx;
    logic             acc;

    assign in_ready = (count != CNT_W'(N));
    assign acc      = in_valid && in_ready;
    assign wr_idx   = load ? '0 : count[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < N; i++) slots[i] <= IDLE_PKT;
        end else begin
            if (load)     count <= acc ? CNT_W'(1) : '0;
            else if (acc) count <= count + 1'b1;
            if (acc) slots[wr_idx] <= in_pkt;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) used[i] = (CNT_W'(i) < count);
    end

endmodule

// File: rtl/spf_frame_build.sv
module spf_frame_build
    import spf_pkg::*;
#(
    parameter int N = SLOTS
) (
    input  pkt_t [N-1:0] slots,
    input  logic [N-1:0] used,
    output frame_t       frame
);
    localparam logic [PAY_W-1:0] KS = keystream();

    logic [PAY_W-1:0] plain;
    logic [N-1:0]     par;

    for (genvar g = 0; g < N; g++) begin : g_slot
        pkt_t p;
        assign p = used[g] ? slots[g] : IDLE_PKT;
        assign par[g] = even_par(p);
        assign plain[PAY_W-1-g*PKT_W -: PKT_W] = p;
    end

    assign frame.hdr.mark = HDR_MARK;
    assign frame.hdr.par  = par;
    assign frame.pay      = plain ^ KS;

endmodule

// File: rtl/spf_byte_shifter.sv
module spf_byte_shifter
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frame_in,
    output logic              load,
    output logic              out_valid,
    output logic              out_sof,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int IDX_W = $clog2(BYTES);

    frame_bytes_t     cur;
    logic [IDX_W-1:0] idx;
    logic             run;

    assign load = !run || (idx == IDX_W'(BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            idx <= '0;
            cur <= '0;
        end else if (load) begin
            run <= 1'b1;
            idx <= '0;
            cur <= frame_bytes_t'(frame_in);
        end else begin
            idx <= idx + 1'b1;
        end
    end

    assign out_valid = run;
    assign out_sof   = run && (idx == '0);
    assign out_byte  = cur[IDX_W'(BYTES - 1) - idx];

endmodule

// File: rtl/sp_frame_packer.sv
module sp_frame_packer
    import spf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PKT_W-1:0]  in_pkt,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_sof,
    output logic [BYTE_W-1:0] out_byte
);
    pkt_t [SLOTS-1:0] slots;
    logic [SLOTS-1:0] used;
    logic             load;
    frame_t           frame;

    spf_collector #(.N(SLOTS)) u_coll (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_ready(in_ready), .load(load), .slots(slots), .used(used)
    );

    spf_frame_build #(.N(SLOTS)) u_build (
        .slots(slots), .used(used), .frame(frame)
    );

    spf_byte_shifter u_shift (
        .clk(clk), .rst(rst), .frame_in(frame), .load(load),
        .out_valid(out_valid), .out_sof(out_sof), .out_byte(out_byte)
    );

endmodule

// File: rtl/spf_checker.sv
module spf_checker
    import spf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_sof,
    input logic [BYTE_W-1:0] out_byte
);
    localparam int PW = $clog2(BYTES);
    logic [PW-1:0] per;

    always_ff @(posedge clk) begin
        if (rst)            per <= '0;
        else if (out_valid) per <= (per == PW'(BYTES - 1)) ? '0 : per + 1'b1;
    end

    AST_RESET_OUT: assert property (@(posedge clk) rst |-> (!out_valid && !out_sof && in_ready)); // R1
    AST_STREAM_CONT: assert property (@(posedge clk) disable iff (rst) out_valid |=> out_valid); // R1
    AST_SOF_PERIOD: assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_sof == (per == '0))); // R2
    AST_HDR_MARK: assert property (@(posedge clk) disable iff (rst) out_sof |-> (out_byte[7:4] == 4'h5)); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst) !in_ready |=> (!in_ready || out_sof)); // R7

endmodule

bind sp_frame_packer spf_checker u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_byte(out_byte)
);

// File: tb/sp_frame_packer_tb.sv
module sp_frame_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [29:0] in_pkt = '0;
    logic        in_ready, out_valid, out_sof;
    logic [7:0]  out_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sp_frame_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pkt(in_pkt),
        .in_ready(in_ready), .out_valid(out_valid), .out_sof(out_sof),
        .out_byte(out_byte)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected frame from the requirements (R3..R6).
    function automatic logic [127:0] build(input logic [29:0] p[4], input int n);
        logic [119:0] pay, ks;
        logic [3:0]   par;
        logic [6:0]   s;
        logic         b;
        s = 7'h7F;
        for (int k = 0; k < 120; k++) begin
            b = s[6] ^ s[5];
            ks[119-k] = b;
            s = {s[5:0], b};
        end
        for (int i = 0; i < 4; i++) begin
            logic [29:0] q;
            q = (i < n) ? p[i] : 30'h0;   // R6 idle fill
            par[i] = ^q;
            pay[119-30*i -: 30] = q;
        end
        return {4'h5, par, pay ^ ks};
    endfunction

    // Scoreboard monitor
    logic [127:0] exp_q[$];
    logic [127:0] cur;
    logic [29:0]  pend[4];
    int           np = 0;
    int           idx = 0;
    bit           started = 1'b0;
    int           frames = 0;

    always @(negedge clk) begin
        if (rst) begin
            chk(!out_valid && !out_sof && in_ready, "R1 reset state",
                {61'h0, out_valid, out_sof, in_ready}, 64'h1);
            started = 1'b0; np = 0;
        end else begin
            bit load, acc;
            if (!started) begin
                chk(!out_valid, "R1 first cycle after reset", out_valid, 0);
                load = 1'b1;
            end else begin
                if (idx == 0) cur = exp_q.pop_front();
                chk(out_valid && (out_sof == (idx == 0)), "R2 valid/sof",
                    {out_valid, out_sof}, {1'b1, idx == 0});
                chk(out_byte == cur[127-8*idx -: 8],
                    (idx == 0) ? "R3 header byte" : "R4/R5/R6/R8 payload byte",
                    out_byte, cur[127-8*idx -: 8]);
                load = (idx == 15);
            end
            chk(in_ready == (np < 4), "R7 ready level", in_ready, np < 4);
            acc = in_valid && in_ready;
            if (load) begin
                exp_q.push_back(build(pend, np));
                np = 0; frames++;
            end
            if (acc && np < 4) begin   // R8: after the load snapshot
                pend[np] = in_pkt; np++;
            end
            idx = (load) ? 0 : idx + 1;
            started = 1'b1;
        end
    end

    task automatic send(input logic [29:0] p);
        in_valid = 1'b1; in_pkt = p;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        idle(40);                       // R6 fully idle frames
        send(30'h2AAA_AAAA);            // R6 partial frame
        idle(40);
        for (int i = 0; i < 12; i++)    // R7 burst fills all slots
            send(30'h3FFF_FFFF - 30'(i));
        idle(10);
        for (int i = 0; i < 200; i++) begin   // R8 random arrivals hit load cycles
            send(30'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 9));
        end
        send(30'h1555_5555);
        send(30'h0000_0001);
        idle(48);
        chk(np == 0, "R4 all packets framed", np, 0);
        chk(frames > 20, "R2 frame count", frames, 21);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk); cyc++;
        end
        if (!done) chk(1'b0, "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule